// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receive side of a serial port running as a synchronous clock master. It makes the shift clock itself from the system clock through a fixed divider. It samples the serial data line on each rising shift-clock edge and builds words of either eight or nine bits, least significant bit first. Each finished word appears as a single-cycle strobe. The low data bits and the extra ninth bit come out on separate outputs.

Software starts reception in one of two ways. A one-cycle pulse on `single_set` arms a one-shot request, and that request takes exactly one word. Hardware clears the request when the word finishes, and `single_pend` shows whether it is still armed. Holding `cont_en` high runs words back to back until software drops it. The continuous enable wins over the one-shot request. When reception stops, the shift clock always halts at a word boundary. Dropping `port_en` holds the whole receiver in reset.

Top module: `sync_rx_master`

## Requirements
- R1: While `rst` is high or `port_en` is low, every state element clears. From the next clock, `sck`, `word_valid`, `word_data`, `word_bit9` and `single_pend` all read 0.
- R2: A one-cycle `single_set` pulse raises `single_pend` on the following clock and starts one word. Hardware drops `single_pend` in the same cycle that `word_valid` reports that word. Further pulses while the request is already pending have no extra effect.
- R3: `sck` is low when no word is in progress. During a word, each bit takes HALF clocks low and then HALF clocks high. The first low phase begins on the clock after the start condition (`cont_en` or a pending one-shot request) is seen while idle.
- R4: Bit k of a word (k = 0 first) is the value of `rx_in` in the clock cycle just before `sck` rises for the (k+1)-th time in that word. Bit k goes to `word_data[k]`.
- R5: `word_valid` is high for exactly one clock. That clock directly follows the clock in which `sck` fell for the last bit of the word. `word_data` and `word_bit9` carry the word in that cycle and hold it until the next word.
- R6: With `nine_bit` = 1 a word has 9 bits, and the last bit goes to `word_bit9`. With `nine_bit` = 0 a word has 8 bits and `word_bit9` reads 0. `nine_bit` is taken at the start of each word, so a change mid-word affects only the next word.
- R7: While `cont_en` is high, a new word's first low phase follows the previous word's final falling edge with no idle clock between.
- R8: If `cont_en` drops mid-word, the current word still completes and is reported. `sck` then stays low.
- R9: With `cont_en` and a one-shot request both active, reception keeps running past the first word. The one-shot request is still cleared when that first word completes.
- R10: If a `single_set` pulse falls in the same clock that completes a word, the new request wins. `single_pend` stays 1, and the next word starts with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Port enable; low holds the receiver in reset |
| nine_bit | input | 1 | 1 selects 9-bit words, 0 selects 8-bit words |
| single_set | input | 1 | One-cycle pulse arming a single-word receive |
| cont_en | input | 1 | Level enable for continuous reception |
| rx_in | input | 1 | Serial data line |
| sck | output | 1 | Generated shift clock |
| word_valid | output | 1 | One-cycle strobe per completed word |
| word_data | output | DATA_W | Low data bits of the completed word |
| word_bit9 | output | 1 | Ninth bit of the completed word (0 in 8-bit mode) |
| single_pend | output | 1 | One-shot receive request still armed |

## Verification
Two events can land in one clock: hardware clearing the one-shot request at word completion, and software arming it again. The bench watches its reference model's phase counter. It pulses `single_set` in exactly the clock where the final falling edge of the word happens. That run must show `single_pend` held high and a second word starting at once. A stretch with both enables set checks that the continuous enable wins while the one-shot flag is still cleared at the first boundary.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } sck_phase_t;
endpackage

// File: rtl/srx_sclk_gen.sv
module srx_sclk_gen
  import srx_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic start,
  input  logic keep_going,
  output logic sck,
  output logic rise_evt,
  output logic fall_evt,
  output logic idle
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF - 1);

  sck_phase_t     phase;
  logic [CW-1:0]  cnt;
  logic           at_end;

  assign at_end   = (cnt == CNT_LAST);
  assign rise_evt = (phase == PH_LOW)  && at_end;
  assign fall_evt = (phase == PH_HIGH) && at_end;
  assign idle     = (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (clr) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      sck   <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (start) phase <= PH_LOW;
        end
        PH_LOW: begin
          if (at_end) begin
            phase <= PH_HIGH;
            cnt   <= '0;
            sck   <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (at_end) begin
            cnt   <= '0;
            sck   <= 1'b0;
            phase <= keep_going ? PH_LOW : PH_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
          sck   <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/srx_word_asm.sv
module srx_word_asm #(
  parameter int WORD_W = 9,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              sample_en,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              rx_in,
  output logic [WORD_W-1:0] shreg
);
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (clr)
        shreg[i] <= 1'b0;
      else if (sample_en && (bit_idx == IDX_W'(i)))
        shreg[i] <= rx_in;
    end
  end
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl #(
  parameter int DATA_W = 8,
  parameter int WORD_W = DATA_W + 1,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              cont_en,
  input  logic              single_set,
  input  logic              nine_bit,
  input  logic              idle,
  input  logic              fall_evt,
  input  logic [WORD_W-1:0] shreg,
  output logic              start,
  output logic              keep_going,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data,
  output logic              word_bit9,
  output logic              single_pend
);
  logic             w9;
  logic [IDX_W-1:0] last_idx;
  logic             is_last;
  logic             word_done;

  assign last_idx   = w9 ? IDX_W'(WORD_W - 1) : IDX_W'(DATA_W - 1);
  assign is_last    = (bit_idx == last_idx);
  assign word_done  = fall_evt && is_last;
  assign start      = idle && (cont_en || single_pend);
  assign keep_going = !is_last || cont_en || single_set;

  always_ff @(posedge clk) begin
    if (clr) begin
      bit_idx     <= '0;
      w9          <= 1'b0;
      word_valid  <= 1'b0;
      word_data   <= '0;
      word_bit9   <= 1'b0;
      single_pend <= 1'b0;
    end else begin
      word_valid <= word_done;
      if (start) begin
        bit_idx <= '0;
        w9      <= nine_bit;
      end else if (fall_evt) begin
        if (is_last) begin
          bit_idx <= '0;
          w9      <= nine_bit;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
      if (word_done) begin
        word_data <= shreg[DATA_W-1:0];
        word_bit9 <= w9 & shreg[WORD_W-1];
      end
      if (single_set)
        single_pend <= 1'b1;
      else if (word_done)
        single_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master #(
  parameter int DATA_W = 8,
  parameter int HALF   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic              nine_bit,
  input  logic              single_set,
  input  logic              cont_en,
  input  logic              rx_in,
  output logic              sck,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data,
  output logic              word_bit9,
  output logic              single_pend
);
  localparam int WORD_W = DATA_W + 1;
  localparam int IDX_W  = $clog2(WORD_W + 1);

  logic              clr;
  logic              start;
  logic              keep_going;
  logic              rise_evt;
  logic              fall_evt;
  logic              idle;
  logic [IDX_W-1:0]  bit_idx;
  logic [WORD_W-1:0] shreg;

  assign clr = rst || !port_en;

  srx_sclk_gen #(.HALF(HALF)) u_sclk (
    .clk(clk), .clr(clr), .start(start), .keep_going(keep_going),
    .sck(sck), .rise_evt(rise_evt), .fall_evt(fall_evt), .idle(idle)
  );

  srx_word_asm #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_asm (
    .clk(clk), .clr(clr), .sample_en(rise_evt), .bit_idx(bit_idx),
    .rx_in(rx_in), .shreg(shreg)
  );

  srx_ctrl #(.DATA_W(DATA_W), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .clr(clr), .cont_en(cont_en), .single_set(single_set),
    .nine_bit(nine_bit), .idle(idle), .fall_evt(fall_evt), .shreg(shreg),
    .start(start), .keep_going(keep_going), .bit_idx(bit_idx),
    .word_valid(word_valid), .word_data(word_data), .word_bit9(word_bit9),
    .single_pend(single_pend)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic clk,
  input logic rst,
  input logic port_en,
  input logic sck,
  input logic word_valid,
  input logic single_pend
);
  AST_HOLD_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> (!sck && !word_valid && !single_pend)); // R1

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid); // R5

  AST_STROBE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (!sck && $past(sck))); // R5

  AST_PEND_CLEARS_ON_WORD: assert property (@(posedge clk) disable iff (rst)
    ($fell(single_pend) && $past(port_en) && port_en) |-> word_valid); // R2
endmodule

bind sync_rx_master srx_checker u_srx_checker (
  .clk(clk), .rst(rst), .port_en(port_en), .sck(sck),
  .word_valid(word_valid), .single_pend(single_pend)
);

// File: tb/test_sync_rx_master.sv
module test_sync_rx_master;
  localparam int DW = 8;
  localparam int H  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_en = 1'b0, nine_bit = 1'b0, single_set = 1'b0, cont_en = 1'b0, rx_in = 1'b0;
  logic sck, word_valid, word_bit9, single_pend;
  logic [DW-1:0] word_data;

  sync_rx_master #(.DATA_W(DW), .HALF(H)) i_sync_rx_master (
    .clk(clk), .rst(rst), .port_en(port_en), .nine_bit(nine_bit),
    .single_set(single_set), .cont_en(cont_en), .rx_in(rx_in),
    .sck(sck), .word_valid(word_valid), .word_data(word_data),
    .word_bit9(word_bit9), .single_pend(single_pend)
  );

  always #5 clk = ~clk;

  int vectors = 0, errors = 0, n_words = 0, cycles = 0;

  // behavioural reference
  int m_phase = 0, m_cnt = 0, m_idx = 0;
  bit m_w9 = 0, m_sck = 0, m_valid = 0, m_b9 = 0, m_arm = 0;
  bit [DW:0] m_buf = '0;
  bit [DW-1:0] m_data = '0;

  always @(posedge clk) begin
    bit done;
    done = 0;
    if (rst || !port_en) begin
      m_phase = 0; m_cnt = 0; m_idx = 0; m_w9 = 0; m_sck = 0;
      m_valid = 0; m_b9 = 0; m_arm = 0; m_buf = '0; m_data = '0;
    end else begin
      m_valid = 0;
      if (m_phase == 0) begin
        if (cont_en || m_arm) begin m_phase = 1; m_cnt = 0; m_idx = 0; m_w9 = nine_bit; end
      end else if (m_phase == 1) begin
        if (m_cnt == H-1) begin m_buf[m_idx] = rx_in; m_sck = 1; m_phase = 2; m_cnt = 0; end
        else m_cnt++;
      end else begin
        if (m_cnt == H-1) begin
          m_sck = 0; m_cnt = 0;
          if (m_idx == (m_w9 ? DW : DW-1)) begin
            done = 1; m_valid = 1;
            m_data = m_buf[DW-1:0];
            m_b9 = m_w9 & m_buf[DW];
            m_w9 = nine_bit; m_idx = 0;
            m_phase = (cont_en || single_set) ? 1 : 0;
          end else begin
            m_idx++; m_phase = 1;
          end
        end else m_cnt++;
      end
      if (single_set) m_arm = 1;
      else if (done) m_arm = 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    chk("R3 R7 R8", "sck", sck, m_sck);
    chk("R5", "word_valid", word_valid, m_valid);
    chk("R4", "word_data", word_data, m_data);
    chk("R6", "word_bit9", word_bit9, m_b9);
    chk("R2 R9 R10", "single_pend", single_pend, m_arm);
    if (word_valid) n_words++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rx_in = lfsr[0];
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_single();
    single_set = 1; @(negedge clk); single_set = 0;
  endtask

  initial begin
    int w0;
    wait_n(3);
    rst = 0;
    wait_n(2);
    chk("R1", "reset sck", sck, 0);
    chk("R1", "reset pend", single_pend, 0);
    port_en = 1;
    wait_n(2);

    // single 8-bit word
    w0 = n_words; pulse_single(); wait_n(45);
    chk("R2", "single 8-bit word count", n_words - w0, 1);
    // single 9-bit word, extra pulse while pending
    nine_bit = 1; w0 = n_words; pulse_single(); wait_n(3); pulse_single(); wait_n(50);
    chk("R6", "single 9-bit word count", n_words - w0, 1);

    // continuous, width change mid-word, stop mid-word
    nine_bit = 0; w0 = n_words; cont_en = 1; wait_n(20);
    nine_bit = 1; wait_n(80);
    cont_en = 0; wait_n(60);
    chk("R7", "continuous words", (n_words - w0) >= 3, 1);
    chk("R8", "sck idle after stop", sck, 0);

    // both enables: continuous wins
    nine_bit = 0; w0 = n_words; cont_en = 1; pulse_single(); wait_n(100);
    cont_en = 0; wait_n(50);
    chk("R9", "both set keeps running", (n_words - w0) >= 2, 1);

    // new request in the completion cycle
    w0 = n_words; pulse_single();
    while (!(m_phase == 2 && m_cnt == H-1 && m_idx == DW-1)) @(negedge clk);
    single_set = 1; @(negedge clk); single_set = 0;
    chk("R10", "pend kept on collision", single_pend, 1);
    wait_n(80);
    chk("R10", "two words from collision", n_words - w0, 2);

    // port disable mid-word
    cont_en = 1; wait_n(15);
    port_en = 0; wait_n(2);
    chk("R1", "disabled sck", sck, 0);
    chk("R1", "disabled data", word_data, 0);
    port_en = 1; wait_n(40);
    cont_en = 0; wait_n(60);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule